// File: doc/BRIEF.md
# Stereo Sample Store with Mute and Ratio Gain

This block sits in front of a sample-rate converter's filter. Each accepted left/right sample pair is scaled in amplitude and written into a circular stereo sample memory. The scale is the product of two gains. The first is a ratio gain that shrinks the input when the converter decimates, so that a longer convolution cannot saturate. The second is a soft-mute level that ramps smoothly between silence and unity, one step per accepted sample. The scaled product is rounded and clipped back to the sample width before it is stored.

The write address is the running count of accepted samples plus a fixed guard offset, taken modulo the memory depth. A read window placed relative to that count therefore never lands on the slot being written. A convolution engine reads both channels through a synchronous port. That port has one cycle of latency and returns the newly written pair when it addresses the slot being written in the same cycle.

The soft-mute controller is a four-state machine:
- MR_UNITY: level at full scale; this is the state after reset.
- MR_FALL: level stepping down.
- MR_SILENT: level at zero.
- MR_RISE: level stepping up.

Transitions are evaluated on every clock from the level the current cycle produces and the mute request:
- T_MUTE: MR_UNITY or MR_RISE goes to MR_FALL when muting is requested and the level is not yet zero.
- T_UNMUTE: MR_SILENT or MR_FALL goes to MR_RISE when muting is released and the level is not yet full.
- T_QUIET: MR_FALL goes to MR_SILENT when the level reaches zero.
- T_FULL: MR_RISE goes to MR_UNITY when the level reaches full scale.

Top module: `stereo_gain_fifo`

## Requirements
- R1: After reset, wr_count is 0 and mute_done is 1, with the mute level at unity.
- R2: On each clock with in_valid high, the scaled pair is written at address (wr_count + GUARD) mod DEPTH, and wr_count then increments by one, wrapping at DEPTH (a power of two). With in_valid low, neither wr_count nor any memory content changes.
- R3: rd_left and rd_right show the memory contents at rd_addr one clock after rd_addr is presented.
- R4: When rd_addr equals the write address in a cycle with in_valid high, the read returns the pair being written.
- R5: The ratio gain is an unsigned Q1.15 value (16'h8000 = 1.0). It applies only when decim_en is 1. With decim_en at 0, the ratio factor is unity.
- R6: The stored value is floor((s × g × m + 2^(S−1)) / 2^S). Here s is the signed input, g is the effective ratio gain, m is the mute level (0 to MUTE_STEPS), and S = 15 + log2(MUTE_STEPS). Halves round toward plus infinity.
- R7: A result outside the signed DATA_W range is clipped to 0x7FFFFF or 0x800000 (for DATA_W = 24).
- R8: One clock after mute_req rises at unity, the ramp falls. Each accepted sample is scaled by the level before that sample's step, and the level then drops by one. After MUTE_STEPS samples, stored samples are zero.
- R9: After mute_req falls, the level rises by one per accepted sample in the same way, until unity is reached.
- R10: Toggling mute_req during a ramp reverses the direction from the current level without a jump.
- R11: mute_done is 0 while the level is ramping and 1 once it sits at the requested end (zero or unity).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept the input pair this cycle |
| in_left | input | DATA_W | Left input sample, signed |
| in_right | input | DATA_W | Right input sample, signed |
| decim_en | input | 1 | Output rate below input rate; enables ratio gain |
| ratio_gain | input | 16 | Unsigned Q1.15 ratio gain |
| mute_req | input | 1 | 1 requests silence, 0 requests unity |
| mute_done | output | 1 | Mute level has reached its requested end |
| wr_count | output | ADDR_W | Count of accepted samples, modulo DEPTH |
| rd_addr | input | ADDR_W | Read address |
| rd_left | output | DATA_W | Left read data, one cycle latency |
| rd_right | output | DATA_W | Right read data, one cycle latency |

## Verification
The bench builds the block with DEPTH = 32, GUARD = 4 and MUTE_STEPS = 16, keeping the default 24-bit samples. With these values the address wrap and the guard-shifted write slot are reached after 32 samples. A complete fall or rise of the mute ramp takes only 16 samples, so the reversal points mid-ramp can be placed exactly. The total scaling shift is 19 bits, which keeps every rounding and clipping case hand-computable with exact half-way values.

// File: rtl/sgf_pkg.sv
package sgf_pkg;
    typedef enum logic [1:0] {
        MR_UNITY  = 2'd0,
        MR_FALL   = 2'd1,
        MR_SILENT = 2'd2,
        MR_RISE   = 2'd3
    } mute_state_e;

    localparam int RATIO_W    = 16;
    localparam int RATIO_FRAC = 15;
    localparam logic [RATIO_W-1:0] RATIO_ONE = 16'h8000;
endpackage

// File: rtl/mute_ramp.sv
module mute_ramp
    import sgf_pkg::*;
#(
    parameter int STEPS = 256,
    localparam int LVL_W = $clog2(STEPS) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             mute_req,
    output logic [LVL_W-1:0] level,
    output logic             done
);
    localparam logic [LVL_W-1:0] FULL = LVL_W'(STEPS);

    mute_state_e      state_q, state_d;
    logic [LVL_W-1:0] level_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MR_UNITY;
            level   <= FULL;
        end else begin
            state_q <= state_d;
            level   <= level_d;
        end
    end

    // level stepping and transitions
    always_comb begin
        level_d = level;
        unique case (state_q)
            MR_FALL:   if (step_en) level_d = level - 1'b1;
            MR_RISE:   if (step_en) level_d = level + 1'b1;
            MR_UNITY,
            MR_SILENT: level_d = level;
        endcase
        if (mute_req)
            state_d = (level_d == '0) ? MR_SILENT : MR_FALL;
        else
            state_d = (level_d == FULL) ? MR_UNITY : MR_RISE;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            MR_UNITY, MR_SILENT: done = 1'b1;
            MR_FALL,  MR_RISE:   done = 1'b0;
        endcase
    end

    // R10: the level never moves by more than one step per clock
    a_r10_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (level == $past(level)) || (level == $past(level) + 1'b1)
               || (level == $past(level) - 1'b1));

    // R8: a falling ramp drops one level per accepted sample
    a_r8_fall_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MR_FALL && step_en) |=> level == $past(level) - 1'b1);

    // R11: completion is only flagged at an end point
    a_r11_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (level == '0 || level == FULL));
endmodule

// File: rtl/gain_scaler.sv
module gain_scaler
    import sgf_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int STEPS  = 256,
    localparam int LVL_W = $clog2(STEPS) + 1,
    localparam int SHIFT = RATIO_FRAC + $clog2(STEPS),
    localparam int GW    = RATIO_W + LVL_W,
    localparam int PW    = DATA_W + GW + 1
) (
    input  logic signed [DATA_W-1:0]  sample,
    input  logic        [RATIO_W-1:0] ratio,
    input  logic        [LVL_W-1:0]   level,
    output logic signed [DATA_W-1:0]  scaled
);
    localparam logic signed [PW-1:0] RND  = PW'(1) <<< (SHIFT - 1);
    localparam logic signed [PW-1:0] MAXV = PW'((64'd1 << (DATA_W - 1)) - 1);
    localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

    logic        [GW-1:0] gain;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shifted;

    always_comb begin
        gain    = GW'(ratio) * GW'(level);
        prod    = PW'(sample) * $signed({1'b0, gain});
        shifted = (prod + RND) >>> SHIFT;
        if (shifted > MAXV)      scaled = MAXV[DATA_W-1:0];
        else if (shifted < MINV) scaled = MINV[DATA_W-1:0];
        else                     scaled = shifted[DATA_W-1:0];
    end
endmodule

// File: rtl/stereo_ram.sv
module stereo_ram #(
    parameter int DATA_W = 24,
    parameter int DEPTH  = 512,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [1:0][DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [1:0][DATA_W-1:0] rd_data
);
    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        logic [DATA_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en) mem[wr_addr] <= wr_data[ch];
            if (wr_en && wr_addr == rd_addr) rd_data[ch] <= wr_data[ch];
            else                             rd_data[ch] <= mem[rd_addr];
        end
    end

    // R4: a colliding read sees the pair being written
    a_r4_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == rd_addr) |=> rd_data == $past(wr_data));
endmodule

// File: rtl/stereo_gain_fifo.sv
module stereo_gain_fifo
    import sgf_pkg::*;
#(
    parameter int DATA_W     = 24,
    parameter int DEPTH      = 512,
    parameter int GUARD      = 16,
    parameter int MUTE_STEPS = 256,
    localparam int ADDR_W    = $clog2(DEPTH),
    localparam int LVL_W     = $clog2(MUTE_STEPS) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [DATA_W-1:0]   in_left,
    input  logic [DATA_W-1:0]   in_right,
    input  logic                decim_en,
    input  logic [RATIO_W-1:0]  ratio_gain,
    input  logic                mute_req,
    output logic                mute_done,
    output logic [ADDR_W-1:0]   wr_count,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_left,
    output logic [DATA_W-1:0]   rd_right
);
    logic [RATIO_W-1:0]     ratio_eff;
    logic [LVL_W-1:0]       level;
    logic [ADDR_W-1:0]      wr_addr;
    logic [1:0][DATA_W-1:0] raw, scaled, rd_data;

    assign ratio_eff = decim_en ? ratio_gain : RATIO_ONE;
    assign wr_addr   = wr_count + ADDR_W'(GUARD);
    assign raw       = {in_right, in_left};
    assign rd_left   = rd_data[0];
    assign rd_right  = rd_data[1];

    always_ff @(posedge clk) begin
        if (!rst_n)        wr_count <= '0;
        else if (in_valid) wr_count <= wr_count + 1'b1;
    end

    mute_ramp #(.STEPS(MUTE_STEPS)) u_ramp (
        .clk(clk), .rst_n(rst_n), .step_en(in_valid),
        .mute_req(mute_req), .level(level), .done(mute_done)
    );

    for (genvar ch = 0; ch < 2; ch++) begin : g_scale
        gain_scaler #(.DATA_W(DATA_W), .STEPS(MUTE_STEPS)) u_scale (
            .sample(raw[ch]), .ratio(ratio_eff), .level(level),
            .scaled(scaled[ch])
        );
    end

    stereo_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
        .clk(clk), .rst_n(rst_n), .wr_en(in_valid), .wr_addr(wr_addr),
        .wr_data(scaled), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // R2: one accepted sample advances the count by exactly one
    a_r2_count_advance: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> wr_count == $past(wr_count) + 1'b1);

    // R2: without a sample the count holds
    a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(wr_count));
endmodule

// File: tb/tb_stereo_gain_fifo.sv
`timescale 1ns/1ps
module tb_stereo_gain_fifo;
    localparam int DW = 24, DEPTH = 32, GUARD = 4, STEPS = 16, AW = 5;

    logic clk = 0, rst_n = 0, in_valid = 0, decim_en = 0, mute_req = 0;
    logic [DW-1:0] in_left = '0, in_right = '0, rd_left, rd_right;
    logic [15:0] ratio_gain = 16'h8000;
    logic mute_done;
    logic [AW-1:0] wr_count, rd_addr = '0;

    int checks = 0, failures = 0, cnt = 0;
    logic [DW-1:0] shadow_l [DEPTH];

    always #2.5 clk = ~clk;

    stereo_gain_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .GUARD(GUARD),
                       .MUTE_STEPS(STEPS)) dut (.*);

    // {left, right, decim, ratio, expected left, expected right}
    localparam logic [112:0] VEC [8] = '{
        {24'h000123, 24'hFFFFFF, 1'b0, 16'h1234, 24'h000123, 24'hFFFFFF},
        {24'h100000, 24'hF00000, 1'b1, 16'h4000, 24'h080000, 24'hF80000},
        {24'h000003, 24'hFFFFFD, 1'b1, 16'h4000, 24'h000002, 24'hFFFFFF},
        {24'h7FFFFF, 24'h800000, 1'b1, 16'hFFFF, 24'h7FFFFF, 24'h800000},
        {24'h7FFFFF, 24'h800000, 1'b0, 16'hFFFF, 24'h7FFFFF, 24'h800000},
        {24'h400000, 24'h000001, 1'b1, 16'hC000, 24'h600000, 24'h000002},
        {24'h400000, 24'hC00000, 1'b1, 16'h0000, 24'h000000, 24'h000000},
        {24'h000005, 24'hFFFFFB, 1'b1, 16'h2000, 24'h000001, 24'hFFFFFF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [DW-1:0] l, input logic [DW-1:0] r,
                        input logic d, input logic [15:0] g);
        @(negedge clk);
        in_valid = 1; in_left = l; in_right = r; decim_en = d; ratio_gain = g;
        @(negedge clk);
        in_valid = 0;
        cnt = (cnt + 1) % DEPTH;
    endtask

    task automatic rd(input int a);
        @(negedge clk);
        rd_addr = AW'(a);
        @(negedge clk);
    endtask

    function automatic int waddr();
        return (cnt + GUARD) % DEPTH;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int a;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 count", 32'(wr_count), 0);
        chk("R1 done", 32'(mute_done), 1);

        // table walk: R5 R6 R7 R2 R3
        foreach (VEC[i]) begin
            a = waddr();
            push(VEC[i][112:89], VEC[i][88:65], VEC[i][64], VEC[i][63:48]);
            shadow_l[a] = VEC[i][47:24];
            chk("R2 count", 32'(wr_count), 32'(cnt));
            rd(a);
            chk("R3/R5/R6/R7 left", 32'(rd_left), 32'(VEC[i][47:24]));
            chk("R3/R5/R6/R7 right", 32'(rd_right), 32'(VEC[i][23:0]));
        end

        // R2: idle cycles change nothing
        repeat (5) @(negedge clk);
        chk("R2 idle count", 32'(wr_count), 32'(cnt));
        rd(GUARD);
        chk("R2 idle data", 32'(rd_left), 32'(shadow_l[GUARD]));

        // R4: collision returns new data
        a = waddr();
        @(negedge clk);
        rd_addr = AW'(a);
        in_valid = 1; in_left = 24'h0ABCDE; in_right = 24'h012345; decim_en = 0;
        @(negedge clk);
        in_valid = 0;
        cnt = (cnt + 1) % DEPTH;
        shadow_l[a] = 24'h0ABCDE;
        chk("R4 left", 32'(rd_left), 32'h0ABCDE);
        chk("R4 right", 32'(rd_right), 32'h012345);

        // R2: wrap of count and guard-shifted address
        while (cnt != 0) begin
            a = waddr();
            push(24'(cnt * 3), 24'h0, 0, 16'h8000);
            shadow_l[a] = 24'(((cnt + DEPTH - 1) % DEPTH) * 3);
        end
        chk("R2 wrap count", 32'(wr_count), 0);
        rd(0);
        chk("R2 wrap addr0", 32'(rd_left), 32'(shadow_l[0]));

        // R8 / R11: fall to silence
        @(negedge clk);
        mute_req = 1;
        @(negedge clk);
        chk("R11 ramping", 32'(mute_done), 0);
        for (int k = 0; k <= STEPS; k++) begin
            a = waddr();
            push(24'h100000, 24'h100000, 0, 16'h8000);
            if (k == STEPS - 2) chk("R11 still ramping", 32'(mute_done), 0);
            rd(a);
            chk("R8 fall level", 32'(rd_left), 32'(65536 * (STEPS - k)));
        end
        chk("R11 silent done", 32'(mute_done), 1);

        // R9 / R10: partial rise, reverse, then rise to unity
        mute_req = 0;
        @(negedge clk);
        chk("R9 rising", 32'(mute_done), 0);
        for (int k = 0; k < 5; k++) begin
            a = waddr();
            push(24'h100000, 24'h100000, 0, 16'h8000);
            rd(a);
            chk("R9 rise level", 32'(rd_right), 32'(65536 * k));
        end
        mute_req = 1;
        @(negedge clk);
        for (int k = 5; k > 2; k--) begin
            a = waddr();
            push(24'h100000, 24'h100000, 0, 16'h8000);
            rd(a);
            chk("R10 reversed fall", 32'(rd_left), 32'(65536 * k));
        end
        mute_req = 0;
        @(negedge clk);
        for (int k = 2; k < STEPS; k++) begin
            a = waddr();
            push(24'h100000, 24'h100000, 0, 16'h8000);
            rd(a);
            chk("R10 reversed rise", 32'(rd_left), 32'(65536 * k));
        end
        chk("R11 unity done", 32'(mute_done), 1);
        a = waddr();
        push(24'h100000, 24'h100000, 0, 16'h8000);
        rd(a);
        chk("R9 unity", 32'(rd_left), 32'h100000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule